// File: doc/BRIEF.md
# Reloading Down-Count Timer Channel

This block is one channel of a peripheral timer. Software reaches it through a small word-wide register port. The port holds a reload value, the live count, a control word and a spare capture word. While the channel's run input is high, an internal prescaler divides the clock by a power of four chosen in the control word. Each prescaled tick decrements the count by one.

When a tick finds the count at zero, the counter takes the reload value instead of wrapping, and a sticky underflow flag sets. Software can only clear the flag, by writing zero to its bit; it can never set it. A registered interrupt line follows the flag whenever the interrupt enable bit is on. Pausing the channel freezes the count and rewinds the prescaler, so a restart always begins a full prescale period.

Top module: `dcnt_channel`

## Requirements
- R1: After reset, the reload word (offset 0x0) and the count (offset 0x4) read 0xFFFFFFFF, the control word (offset 0x8) reads zero, the channel is stopped and `irq` is low.
- R2: Control bits [2:0] hold a prescale code. Codes 0 to 4 divide the clock by 4, 16, 64, 256 and 1024. With `run_en` high, the count drops by one on every Nth rising edge, the first drop on the Nth edge after `run_en` rises.
- R3: Prescale codes 5, 6 and 7 produce no ticks, so the count holds even while running.
- R4: When a tick arrives with the count at zero, the next count is the reload value and the underflow flag (control bit 8) sets on the same edge.
- R5: A control write with bit 8 at zero clears the underflow flag. A write with bit 8 at one leaves the flag as it was, and never sets it.
- R6: A control read returns the stored bits [7:0] (bit 5 is the interrupt enable), the underflow flag in bit 8, and zero in bits [31:9], whatever was written there.
- R7: While `run_en` is low the count holds and the prescaler phase is cleared, so a pause shorter than one full period is never combined with an earlier partial period.
- R8: `irq` equals the underflow flag ANDed with control bit 5, delayed by one clock.
- R9: Writing offset 0x0 sets the reload value, and writing offset 0x4 loads the count directly. A count write wins over a tick on the same edge.
- R10: With the capture feature on, offset 0xC is plain read/write storage that resets to zero. With it off, that offset reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Start enable; high lets the channel count |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte offset; bits [3:2] pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Registered underflow interrupt |

## Verification
The counting path is tried with the shortest divider running through a full reload, with a mid-range and the longest divider stopped one edge short of a tick and then one edge on, and with the reserved codes left running for a long time. The edge-exact checks separate a correct period from an off-by-one. A short run, a pause and a short run again separate a prescaler that is cleared on stop from one that keeps its phase. Flag checks cover writes of one and of zero with the interrupt enable on and off, which separates set, clear and gating from each other.

// File: rtl/dcnt_pkg.sv
// Package: shared types and field positions for the down-count timer channel.
// Assumes word-aligned offsets; byte address bits [3:2] pick the register.
package dcnt_pkg;
    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_CAPT   = 2'd3
    } dcnt_sel_e;

    localparam int CTL_CODE_W   = 3;   // prescale code field width, bits [2:0]
    localparam int CTL_IE_BIT   = 5;   // interrupt enable
    localparam int CTL_FLAG_BIT = 8;   // underflow flag (read), clear-on-zero (write)
    localparam int CTL_KEEP_W   = 8;   // stored control bits [7:0]
endpackage

// File: rtl/dcnt_prescaler.sv
// Module: dcnt_prescaler
// Makes a one-cycle tick every 4^(code+1) clocks while running. Codes at or
// above MAX_EXP never tick. The phase counter is held at zero while stopped,
// so each start begins a full period. Assumes code is steady while running.
module dcnt_prescaler #(
    parameter int CODE_W  = 3,
    parameter int MAX_EXP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int PS_W = 2 * MAX_EXP;

    logic [PS_W-1:0] phase_q;
    logic [PS_W-1:0] mask;
    logic            code_ok;

    // Purpose: select the low-bit mask that marks the end of a period.
    always_comb begin
        mask    = '0;
        code_ok = 1'b0;
        for (int i = 0; i < MAX_EXP; i++) begin
            if (code == CODE_W'(i)) begin
                mask    = PS_W'((1 << (2 * (i + 1))) - 1);
                code_ok = 1'b1;
            end
        end
    end

    assign tick = run && code_ok && ((phase_q & mask) == mask);

    // Purpose: advance the phase while running, clear it while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)   phase_q <= '0;
        else if (!run) phase_q <= '0;
        else          phase_q <= phase_q + 1'b1;
    end

    // R7: a stop rewinds the phase
    a_r7_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase_q == '0));
    // R3: reserved codes never tick
    a_r3_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (code >= CODE_W'(MAX_EXP)) |-> !tick);
endmodule

// File: rtl/dcnt_core.sv
// Module: dcnt_core
// Down counter with reload. A direct load wins over a tick. A tick at zero
// takes the reload value and pulses underflow in the same cycle.
module dcnt_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_cnt,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] count,
    output logic              underflow
);
    assign underflow = tick && (count == '0);

    // Purpose: load, reload on underflow, or decrement on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '1;
        else if (load_cnt) count <= load_val;
        else if (tick)     count <= (count == '0) ? reload_val : count - 1'b1;
    end

    // R7: no tick and no load leaves the count alone
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_cnt) |=> $stable(count));
    // R4: a tick at zero takes the reload value
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == '0 && !load_cnt) |=> (count == $past(reload_val)));
    // R9: a direct load wins
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt |=> (count == $past(load_val)));
endmodule

// File: rtl/dcnt_channel.sv
// Module: dcnt_channel (top)
// One reloading down-count timer channel with a word register port.
// Holds the register file, underflow flag and interrupt, and uses the
// prescaler and counter core. Assumes single-cycle write strobes.
module dcnt_channel
    import dcnt_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int MAX_EXP     = 5,
    parameter bit HAS_CAPTURE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    dcnt_sel_e             sel;
    logic [DATA_W-1:0]     reload_q;
    logic [CTL_KEEP_W-1:0] ctrl_q;
    logic                  flag_q;
    logic [DATA_W-1:0]     capt_q;
    logic [DATA_W-1:0]     count;
    logic                  tick;
    logic                  underflow;
    logic                  wr_reload, wr_count, wr_ctrl;

    assign sel       = dcnt_sel_e'(bus_addr[3:2]);
    assign wr_reload = bus_wr && (sel == SEL_RELOAD);
    assign wr_count  = bus_wr && (sel == SEL_COUNT);
    assign wr_ctrl   = bus_wr && (sel == SEL_CTRL);

    // Purpose: store the reload value and the kept control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '1;
            ctrl_q   <= '0;
        end else begin
            if (wr_reload) reload_q <= bus_wdata;
            if (wr_ctrl)   ctrl_q   <= bus_wdata[CTL_KEEP_W-1:0];
        end
    end

    // Purpose: underflow flag, set by hardware, cleared by writing zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (underflow) flag_q <= 1'b1;
        else if (wr_ctrl && !bus_wdata[CTL_FLAG_BIT]) flag_q <= 1'b0;
    end

    // Purpose: registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= flag_q && ctrl_q[CTL_IE_BIT];
    end

    generate
        if (HAS_CAPTURE) begin : g_capt
            // Purpose: plain storage for the capture word.
            always_ff @(posedge clk) begin
                if (!rst_n)                          capt_q <= '0;
                else if (bus_wr && sel == SEL_CAPT)  capt_q <= bus_wdata;
            end
        end else begin : g_no_capt
            assign capt_q = '0;
        end
    endgenerate

    // Purpose: read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_RELOAD: bus_rdata = reload_q;
            SEL_COUNT:  bus_rdata = count;
            SEL_CTRL: begin
                bus_rdata[CTL_KEEP_W-1:0] = ctrl_q;
                bus_rdata[CTL_FLAG_BIT]   = flag_q;
            end
            default:    bus_rdata = capt_q;
        endcase
    end

    dcnt_prescaler #(.CODE_W(CTL_CODE_W), .MAX_EXP(MAX_EXP)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_en),
        .code  (ctrl_q[CTL_CODE_W-1:0]),
        .tick  (tick)
    );

    dcnt_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_cnt   (wr_count),
        .load_val   (bus_wdata),
        .reload_val (reload_q),
        .count      (count),
        .underflow  (underflow)
    );

    // R4: an underflow always leaves the flag set
    a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> flag_q);
    // R5: software can never raise the flag
    a_r5_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!underflow && !flag_q) |=> !flag_q);
    // R8: a rising interrupt follows an enabled flag
    a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(flag_q && ctrl_q[CTL_IE_BIT]));
    // R8: the interrupt drops one cycle after the flag clears
    a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_q |=> !irq);
endmodule

// File: tb/sim_dcnt_channel.sv
module sim_dcnt_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dcnt_channel u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic run_edges(input int n);
        @(negedge clk);
        run_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        run_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(4'h0, d); check("R1 reload", d, 32'hFFFF_FFFF);
        rd(4'h4, d); check("R1 count", d, 32'hFFFF_FFFF);
        rd(4'h8, d); check("R1 ctrl", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_underflow;
        logic [31:0] d;
        wr(4'h0, 32'd5);
        wr(4'h4, 32'd3);
        wr(4'h8, 32'h20);
        rd(4'h0, d); check("R9 reload write", d, 32'd5);
        run_edges(16);
        rd(4'h4, d); check("R4 reloaded", d, 32'd5);
        rd(4'h8, d); check("R4 flag set", d, 32'h120);
        @(negedge clk);
        check("R8 irq up", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_flag;
        logic [31:0] d;
        wr(4'h8, 32'h100);
        rd(4'h8, d); check("R5 write one keeps flag", d, 32'h100);
        @(negedge clk); @(negedge clk);
        check("R8 irq gated off", {31'b0, irq}, 32'h0);
        wr(4'h8, 32'h120);
        @(negedge clk);
        check("R8 irq re-enabled", {31'b0, irq}, 32'h1);
        wr(4'h8, 32'h020);
        rd(4'h8, d); check("R5 write zero clears", d, 32'h020);
        @(negedge clk);
        check("R8 irq down", {31'b0, irq}, 32'h0);
        wr(4'h8, 32'h120);
        rd(4'h8, d); check("R5 write one never sets", d, 32'h020);
    endtask

    task automatic t_dividers;
        logic [31:0] d;
        wr(4'h8, 32'h1);
        wr(4'h4, 32'd10);
        run_edges(32);
        rd(4'h4, d); check("R2 div16", d, 32'd8);
        wr(4'h8, 32'h4);
        wr(4'h4, 32'd10);
        @(negedge clk);
        run_en = 1'b1;
        repeat (1023) @(posedge clk);
        @(negedge clk);
        rd(4'h4, d); check("R2 div1024 edge 1023", d, 32'd10);
        @(negedge clk);
        rd(4'h4, d); check("R2 div1024 edge 1024", d, 32'd9);
        run_en = 1'b0;
    endtask

    task automatic t_reserved_code;
        logic [31:0] d;
        for (int c = 5; c < 8; c++) begin
            wr(4'h8, 32'(c));
            wr(4'h4, 32'd7);
            run_edges(2100);
            rd(4'h4, d); check("R3 reserved code holds", d, 32'd7);
        end
    endtask

    task automatic t_pause;
        logic [31:0] d;
        wr(4'h8, 32'h0);
        wr(4'h4, 32'd20);
        run_edges(3);
        @(negedge clk);
        run_edges(3);
        rd(4'h4, d); check("R7 pause rewinds prescaler", d, 32'd20);
        repeat (5) @(negedge clk);
        rd(4'h4, d); check("R7 stopped holds", d, 32'd20);
        run_edges(4);
        rd(4'h4, d); check("R2 div4 first tick", d, 32'd19);
        wr(4'h4, 32'd0);
        repeat (20) @(negedge clk);
        rd(4'h8, d); check("R7 no underflow when stopped", d, 32'h0);
    endtask

    task automatic t_ctrl_and_capture;
        logic [31:0] d;
        wr(4'h8, 32'hFFFF_FEFF);
        rd(4'h8, d); check("R6 reserved bits read zero", d, 32'h0000_00FF);
        wr(4'h8, 32'h0);
        wr(4'hC, 32'h1234_5678);
        rd(4'hC, d); check("R10 capture storage", d, 32'h1234_5678);
        rd(4'h0, d); check("R10 reload untouched", d, 32'd5);
    endtask

    task automatic t_load_priority;
        logic [31:0] d;
        wr(4'h8, 32'h0);
        wr(4'h4, 32'd50);
        @(negedge clk);
        run_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        bus_addr = 4'h4; bus_wdata = 32'd33; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; run_en = 1'b0;
        rd(4'h4, d); check("R9 load wins over tick", d, 32'd33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_underflow();
        t_flag();
        t_dividers();
        t_reserved_code();
        t_pause();
        t_ctrl_and_capture();
        t_load_priority();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule